// File: doc/BRIEF.md
# Idle-Detect Power-Down Controller

This block manages power for a peripheral device that sits on a microcontroller's bus. It holds two byte-wide control registers: a configuration register and a blocking register. It also watches the bus address strobe. When automatic power-down is armed and the strobe has not moved for a fixed run of clock cycles, the block raises a power-down flag. Any strobe movement drops the flag at once and starts the idle count again.

The register bits also drive a set of enables. One bit selects a slow, low-power logic mode. Two bits shut off the clock into the logic array and into the output macrocells. A field in the second register blocks individual microcontroller control inputs from the programmable logic. The active-low chip select drives only the memory enables, and power-down also removes them. The logic enables do not depend on chip select.

The register port is a plain write strobe with a one-bit register select. Read data follows the select combinationally. There is no streaming data path, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `idle_pwrdn_ctrl`

## Requirements
- R1: After reset, both registers read 0. `pwr_down` is 0, `low_power` is 0, both clock enables are 1 and every bit of `ctl_pass` is 1.
- R2: A write with `reg_sel`=0 loads all 8 bits of the configuration register. A write with `reg_sel`=1 loads all 8 bits of the blocking register. `reg_rdata` returns the register chosen by `reg_sel`, unchanged, in the same cycle.
- R3: Automatic power-down is armed only while configuration bit 1 is 1. While that bit is 0, `pwr_down` is 0 and the idle count stays at zero.
- R4: While armed, `pwr_down` rises after 15 consecutive rising clock edges at which `strobe` equals its level at the edge before.
- R5: A `strobe` level that differs from the level sampled at the last edge drops `pwr_down` in the same cycle, with no clock edge needed. The idle count then restarts from zero. A strobe that toggles at least every 15 cycles therefore never lets `pwr_down` rise.
- R6: The idle count saturates. `pwr_down` stays 1 for as long as the strobe stays idle and the block stays armed.
- R7: `low_power` equals configuration bit 3: 1 means low-power mode, 0 means full speed.
- R8: `arr_clk_en` is the inverse of configuration bit 4. `mcell_clk_en` is the inverse of configuration bit 5.
- R9: `ctl_pass[i]` is the inverse of blocking-register bit i+2, for i = 0 to 4.
- R10: Every bit of `mem_en` is 1 exactly when `csel_n` is 0 and `pwr_down` is 0. Chip select has no effect on `low_power`, the clock enables or `ctl_pass`.
- R11: Asserting reset while in power-down clears `pwr_down` and disarms the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, used to count idle cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 is configuration, 1 is blocking |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| strobe | input | 1 | Bus address strobe level |
| csel_n | input | 1 | Active-low chip select |
| pwr_down | output | 1 | Power-down flag |
| mem_en | output | 3 | Enables for the three memories |
| arr_clk_en | output | 1 | Clock enable into the logic array |
| mcell_clk_en | output | 1 | Clock enable into the output macrocells |
| low_power | output | 1 | Low-power logic mode select |
| ctl_pass | output | 5 | Per-input pass enables for the control signals |

## Verification
The bench probes the idle threshold at both sides: 14 quiet edges must leave the flag low and the 15th must raise it. A counter that is off by one would fire a cycle early or a cycle late. The strobe is toggled mid-cycle while the flag is high, so a design that only clears the flag on the next clock edge is caught. Two periodic strobe patterns are run, one faster and one slower than the threshold, which exposes a counter that does not restart on a strobe edge. The bench also disarms the block and resets it while the flag is high, and it sweeps chip select with mixed gating bits set, to catch gating that leaks into the wrong output.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int REG_W     = 8;
  localparam int APD_BIT   = 1;
  localparam int TURBO_BIT = 3;
  localparam int ARR_BIT   = 4;
  localparam int MCELL_BIT = 5;
  localparam int CTL_LSB   = 2;

  typedef enum logic {
    SEL_CFG = 1'b0,
    SEL_BLK = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pwr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg,
  output logic [W-1:0] blk,
  output logic [W-1:0] rdata
);
  reg_sel_e sel_e;
  assign sel_e = reg_sel_e'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
      blk <= '0;
    end else if (wr) begin
      if (sel_e == SEL_CFG) cfg <= wdata;
      else                  blk <= wdata;
    end
  end

  always_comb begin
    rdata = (sel_e == SEL_CFG) ? cfg : blk;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int IDLE_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic strobe,
  output logic pwr_down
);
  localparam int CW = $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

  logic [CW-1:0] idle_cnt;
  logic          strobe_q;
  logic          moved;

  assign moved = strobe ^ strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      idle_cnt <= '0;
    end else begin
      strobe_q <= strobe;
      if (!armed || moved)      idle_cnt <= '0;
      else if (idle_cnt != LIMIT) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign pwr_down = armed && (idle_cnt == LIMIT) && !moved;
endmodule

// File: rtl/gate_outputs.sv
module gate_outputs
  import pwr_pkg::*;
#(
  parameter int W       = REG_W,
  parameter int NUM_MEM = 3,
  parameter int NUM_CTL = 5
) (
  input  logic [W-1:0]       cfg,
  input  logic [W-1:0]       blk,
  input  logic               csel_n,
  input  logic               pwr_down,
  output logic [NUM_MEM-1:0] mem_en,
  output logic               arr_clk_en,
  output logic               mcell_clk_en,
  output logic               low_power,
  output logic [NUM_CTL-1:0] ctl_pass
);
  logic mem_ok;
  assign mem_ok = !csel_n && !pwr_down;

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    assign mem_en[m] = mem_ok;
  end

  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    assign ctl_pass[c] = !blk[CTL_LSB + c];
  end

  assign arr_clk_en   = !cfg[ARR_BIT];
  assign mcell_clk_en = !cfg[MCELL_BIT];
  assign low_power    = cfg[TURBO_BIT];
endmodule

// File: rtl/idle_pwrdn_ctrl.sv
module idle_pwrdn_ctrl
  import pwr_pkg::*;
#(
  parameter int DATA_W   = REG_W,
  parameter int IDLE_CYC = 15,
  parameter int NUM_MEM  = 3,
  parameter int NUM_CTL  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               strobe,
  input  logic               csel_n,
  output logic               pwr_down,
  output logic [NUM_MEM-1:0] mem_en,
  output logic               arr_clk_en,
  output logic               mcell_clk_en,
  output logic               low_power,
  output logic [NUM_CTL-1:0] ctl_pass
);
  logic [DATA_W-1:0] cfg;
  logic [DATA_W-1:0] blk;

  pm_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .cfg(cfg), .blk(blk), .rdata(reg_rdata)
  );

  idle_timer #(.IDLE_CYC(IDLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .armed(cfg[APD_BIT]),
    .strobe(strobe), .pwr_down(pwr_down)
  );

  gate_outputs #(.W(DATA_W), .NUM_MEM(NUM_MEM), .NUM_CTL(NUM_CTL)) u_gate (
    .cfg(cfg), .blk(blk), .csel_n(csel_n), .pwr_down(pwr_down),
    .mem_en(mem_en), .arr_clk_en(arr_clk_en), .mcell_clk_en(mcell_clk_en),
    .low_power(low_power), .ctl_pass(ctl_pass)
  );
endmodule

// File: rtl/idle_pwrdn_chk.sv
module idle_pwrdn_chk
  import pwr_pkg::*;
#(
  parameter int DATA_W  = REG_W,
  parameter int NUM_MEM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  cfg,
  input logic [DATA_W-1:0]  blk,
  input logic               strobe,
  input logic               csel_n,
  input logic               pwr_down,
  input logic [NUM_MEM-1:0] mem_en
);
  // R3
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> cfg[APD_BIT]);

  // R5
  quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $stable(strobe));

  // R10
  csel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csel_n |-> (mem_en == '0));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (cfg == $past(reg_wdata)));

  // R2
  blk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (blk == $past(reg_wdata)));
endmodule

bind idle_pwrdn_ctrl idle_pwrdn_chk #(.DATA_W(DATA_W), .NUM_MEM(NUM_MEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .cfg(cfg), .blk(blk), .strobe(strobe),
  .csel_n(csel_n), .pwr_down(pwr_down), .mem_en(mem_en)
);

// File: tb/sim_idle_pwrdn_ctrl.sv
`timescale 1ns/1ps
module sim_idle_pwrdn_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       strobe = 1'b0;
  logic       csel_n = 1'b1;
  logic       pwr_down;
  logic [2:0] mem_en;
  logic       arr_clk_en, mcell_clk_en, low_power;
  logic [4:0] ctl_pass;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  logic [7:0] m_cfg, m_blk;
  logic       m_prev;
  int         m_idle;

  always #4 clk = ~clk;

  idle_pwrdn_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .strobe(strobe),
    .csel_n(csel_n), .pwr_down(pwr_down), .mem_en(mem_en),
    .arr_clk_en(arr_clk_en), .mcell_clk_en(mcell_clk_en),
    .low_power(low_power), .ctl_pass(ctl_pass)
  );

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic check_all();
    bit exp_pd;
    int exp_pass;
    exp_pd = m_cfg[1] && (m_idle >= 15) && (strobe == m_prev);
    exp_pass = 0;
    for (int i = 0; i < 5; i++) if (!m_blk[i+2]) exp_pass |= (1 << i);
    cmp("rdata", reg_rdata, reg_sel ? m_blk : m_cfg);
    cmp("pwr_down", pwr_down, exp_pd);
    cmp("mem_en", mem_en, (!csel_n && !exp_pd) ? 7 : 0);
    cmp("arr_clk_en", arr_clk_en, !m_cfg[4]);
    cmp("mcell_clk_en", mcell_clk_en, !m_cfg[5]);
    cmp("low_power", low_power, m_cfg[3]);
    cmp("ctl_pass", ctl_pass, exp_pass);
  endtask

  // called just after a falling edge with inputs already set
  task automatic tick();
    #2;
    check_all();
    @(posedge clk);
    if (!m_cfg[1] || strobe != m_prev) m_idle = 0;
    else if (m_idle < 15) m_idle++;
    m_prev = strobe;
    if (reg_wr) begin
      if (reg_sel) m_blk = reg_wdata; else m_cfg = reg_wdata;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_cfg = '0; m_blk = '0; m_prev = 1'b0; m_idle = 0;
    @(negedge clk); @(negedge clk);
    check_all();
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    phase = "R1";
    do_reset();
    reg_sel = 1'b1; tick(); reg_sel = 1'b0; tick();

    phase = "R2";
    wr(0, 8'hC4); wr(1, 8'h83);
    reg_sel = 0; tick(); reg_sel = 1; tick();
    wr(1, 8'hFF); wr(0, 8'h00); reg_sel = 1; tick();

    phase = "R9";
    wr(1, 8'h04); wr(1, 8'h7C); wr(1, 8'h40); wr(1, 8'h28); wr(1, 8'h00);

    phase = "R7";
    wr(0, 8'h08); idle(2); wr(0, 8'h00);

    phase = "R8";
    wr(0, 8'h10); wr(0, 8'h20); wr(0, 8'h30); wr(0, 8'h00);

    phase = "R10";
    wr(0, 8'h38); wr(1, 8'h54);
    csel_n = 0; idle(3); csel_n = 1; idle(2); csel_n = 0; idle(2);
    wr(0, 8'h00); wr(1, 8'h00);

    phase = "R3";
    idle(30);
    strobe = 1; tick(); idle(20);

    phase = "R4";
    wr(0, 8'h02);
    idle(14);
    idle(2);

    phase = "R6";
    idle(40);

    phase = "R5";
    strobe = ~strobe; #1;
    cmp("pwr_down immediate", pwr_down, 0);
    tick();
    for (int k = 0; k < 8; k++) begin
      strobe = ~strobe; tick(); idle(9);
    end
    for (int k = 0; k < 4; k++) begin
      strobe = ~strobe; tick(); idle(24);
    end

    phase = "R3";
    wr(0, 8'h00); idle(5);

    phase = "R11";
    wr(0, 8'h02); idle(20);
    do_reset();
    idle(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule